// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Loader

This block holds the register-side update logic for a bank of DAC channels. A host writes each channel's data register over a simple single-cycle write bus. Each channel also has an output latch, and that latch drives the converter code. A per-channel mode bit sets when the latch follows the data register. In immediate mode, a data write also loads the latch at the same clock edge. In deferred mode, the write only stores the value and marks the channel as pending. A later load strobe then moves every pending deferred channel together, so several outputs change on the same edge.

A clear forces a channel's latch to a programmable clear value. The clear comes from that channel's external clear input or from a global clear bit held in the configuration word. It overrides every other latch source and never touches the data register. Each channel also gives a one-cycle pulse whenever its latch is loaded, which lets the surrounding logic, or a bench, see which channels were really reloaded.

Top module: `dac_ldr`

## Requirements
- R1: Address map (AW = 5 for NCH = 8):
  - Address 0 is the configuration word: bit 0 is the load trigger and bit 1 is the global clear.
  - Address 1 holds the mode bits, with bit n for channel n.
  - Addresses NCH+n are the data registers.
  - Addresses 2*NCH+n are the clear-value registers.
  - Writes to any other address change nothing.
- R2: In immediate mode (mode bit 0), writing a channel's data register loads its latch at the same clock edge as the data register.
- R3: In deferred mode (mode bit 1), writing a channel's data register leaves its latch unchanged and marks the channel pending.
- R4: The load trigger is not stored:
  - Each write to address 0 with bit 0 set produces one load strobe, at that write's clock edge.
  - At that edge every channel that is deferred and pending copies its data register into its latch, and its pending mark is removed.
  - A write to address 0 with bit 0 clear loads nothing.
- R5: A load strobe leaves the latch of a channel that is not pending unchanged, and that channel gives no latch-update pulse.
- R6: A clear loads the latch with the channel's clear value at the clock edge, whatever the channel's mode:
  - An external clear applies in each cycle its input is high.
  - The global clear applies in each cycle after it is written as 1, until it is written as 0.
- R7: A clear changes neither the data register nor the pending mark. A later strobe therefore still delivers the data that was written before the clear.
- R8: A clear has priority over an immediate write and over a load strobe in the same cycle. The latch takes the clear value, and a pending mark stays set.
- R9: latch_upd_o[n] is high for exactly the cycle after each edge at which latch n was loaded, from any source.
- R10: After reset, all data registers, latches, clear values and mode bits are 0, nothing is pending, the global clear is off, and no update pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable, one write per cycle |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | BW | Register write data |
| ext_clr_i | input | NCH | Per-channel external clear, active high |
| dac_code_o | output | NCH*DW | Latched output codes, with channel n at bits [n*DW +: DW] |
| latch_upd_o | output | NCH | Per-channel latch-update pulse |

## Verification
- **Assumptions:** The assertions assume that the bus presents at most one write per cycle. They also assume that the inputs are stable at the sampling edge. Given those, a data write and a load strobe can never hit the same channel in the same cycle.
- **Stimulus:** The stimulus drives all inputs on the falling edge, one operation per cycle.
- **Directed cases:** Directed sequences cover each ordering the properties care about:
  - a clear coinciding with a strobe or with an immediate write;
  - a strobe with nothing pending;
  - a mode change while a channel is pending.
- **Random phase:** A random phase follows, with occasional external clears and configuration writes.

// File: rtl/dac_ldr_pkg.sv
package dac_ldr_pkg;
  localparam int unsigned CFG_ADDR      = 0;
  localparam int unsigned MODE_ADDR     = 1;
  localparam int unsigned CFG_LOAD_BIT  = 0;
  localparam int unsigned CFG_GCLR_BIT  = 1;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_CLR,
    SRC_WR,
    SRC_STB
  } ld_src_e;
endpackage

// File: rtl/dac_ldr_regs.sv
module dac_ldr_regs
  import dac_ldr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 5,
  parameter int unsigned BW  = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [BW-1:0]  wr_data_i,
  output logic [NCH-1:0] mode_o,
  output logic           gclr_o,
  output logic           load_stb_o,
  output logic [NCH-1:0] data_we_o,
  output logic [NCH-1:0] clrv_we_o
);
  logic cfg_we, mode_we;

  assign cfg_we     = wr_en_i && (wr_addr_i == AW'(CFG_ADDR));
  assign mode_we    = wr_en_i && (wr_addr_i == AW'(MODE_ADDR));
  // trigger bit is never stored: one strobe per write of 1
  assign load_stb_o = cfg_we && wr_data_i[CFG_LOAD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      gclr_o <= 1'b0;
    end else begin
      if (mode_we) mode_o <= wr_data_i[NCH-1:0];
      if (cfg_we)  gclr_o <= wr_data_i[CFG_GCLR_BIT];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign data_we_o[c] = wr_en_i && (wr_addr_i == AW'(NCH + c));
    assign clrv_we_o[c] = wr_en_i && (wr_addr_i == AW'(2 * NCH + c));
  end

  a_r1_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({data_we_o, clrv_we_o, load_stb_o}) <= 1);

  a_r4_gclr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we |=> $stable(gclr_o));
endmodule

// File: rtl/dac_ldr_chan.sv
module dac_ldr_chan
  import dac_ldr_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_we_i,
  input  logic          clrv_we_i,
  input  logic [DW-1:0] wr_val_i,
  input  logic          mode_i,
  input  logic          load_stb_i,
  input  logic          clr_i,
  output logic [DW-1:0] code_o,
  output logic          upd_o
);
  logic [DW-1:0] data_q, clrv_q, latch_q;
  logic          pend_q;
  ld_src_e       src;

  // priority: clear > immediate write > strobe
  always_comb begin
    src = SRC_NONE;
    if (clr_i)                                 src = SRC_CLR;
    else if (data_we_i && !mode_i)             src = SRC_WR;
    else if (load_stb_i && mode_i && pend_q)   src = SRC_STB;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      clrv_q  <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
      upd_o   <= 1'b0;
    end else begin
      if (data_we_i) data_q <= wr_val_i;
      if (clrv_we_i) clrv_q <= wr_val_i;
      if (data_we_i)             pend_q <= mode_i;
      else if (src == SRC_STB)   pend_q <= 1'b0;
      unique case (src)
        SRC_CLR:  latch_q <= clrv_q;
        SRC_WR:   latch_q <= wr_val_i;
        SRC_STB:  latch_q <= data_q;
        default:  latch_q <= latch_q;
      endcase
      upd_o <= (src != SRC_NONE);
    end
  end

  assign code_o = latch_q;

  a_r2_imm_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && !mode_i && !clr_i |=> (code_o == $past(wr_val_i)) && upd_o);

  a_r3_defer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && mode_i && !clr_i |=> $stable(code_o) && pend_q);

  a_r4_stb_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb_i && mode_i && pend_q && !clr_i |=> (code_o == $past(data_q)) && !pend_q);

  a_r5_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb_i && !pend_q && !clr_i |=> $stable(code_o) && !upd_o);

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (code_o == $past(clrv_q)) && upd_o);

  a_r7_clr_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !data_we_i |=> $stable(data_q) && $stable(pend_q));
endmodule

// File: rtl/dac_ldr.sv
module dac_ldr
  import dac_ldr_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 12,
  parameter int unsigned AW  = $clog2(3 * NCH),
  parameter int unsigned BW  = (DW > NCH) ? DW : NCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BW-1:0]     wr_data_i,
  input  logic [NCH-1:0]    ext_clr_i,
  output logic [NCH*DW-1:0] dac_code_o,
  output logic [NCH-1:0]    latch_upd_o
);
  logic [NCH-1:0] mode, data_we, clrv_we;
  logic           gclr, load_stb;

  dac_ldr_regs #(.NCH(NCH), .AW(AW), .BW(BW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mode_o     (mode),
    .gclr_o     (gclr),
    .load_stb_o (load_stb),
    .data_we_o  (data_we),
    .clrv_we_o  (clrv_we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_ldr_chan #(.DW(DW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .data_we_i  (data_we[c]),
      .clrv_we_i  (clrv_we[c]),
      .wr_val_i   (wr_data_i[DW-1:0]),
      .mode_i     (mode[c]),
      .load_stb_i (load_stb),
      .clr_i      (ext_clr_i[c] | gclr),
      .code_o     (dac_code_o[c*DW +: DW]),
      .upd_o      (latch_upd_o[c])
    );
  end

  a_r8_gclr_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gclr |=> latch_upd_o == {NCH{1'b1}});

  a_r9_upd_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && ext_clr_i == '0 && !gclr |=> latch_upd_o == '0);
endmodule

// File: tb/dac_ldr_test.sv
module dac_ldr_test;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int AW  = 5;
  localparam int BW  = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [BW-1:0]     wr_data = '0;
  logic [NCH-1:0]    ext_clr = '0;
  logic [NCH*DW-1:0] dac_code;
  logic [NCH-1:0]    latch_upd;

  dac_ldr #(.NCH(NCH), .DW(DW), .AW(AW), .BW(BW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ext_clr_i(ext_clr), .dac_code_o(dac_code),
    .latch_upd_o(latch_upd)
  );

  always #2 clk = ~clk;

  typedef struct {
    string             tag;
    logic [NCH*DW-1:0] codes;
    logic [NCH-1:0]    upd;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [DW-1:0]  m_data [NCH];
  logic [DW-1:0]  m_clrv [NCH];
  logic [DW-1:0]  m_latch[NCH];
  logic [NCH-1:0] m_mode = '0, m_pend = '0;
  logic           m_gclr = 1'b0;

  task automatic cyc(string tag, logic wr, int a, logic [BW-1:0] d, logic [NCH-1:0] ex);
    item_t it;
    logic stb;
    @(negedge clk);
    wr_en = wr; wr_addr = AW'(a); wr_data = d; ext_clr = ex;
    stb = wr && a == 0 && d[0];
    for (int c = 0; c < NCH; c++) begin
      logic clr, wd, wc;
      clr = ex[c] | m_gclr;
      wd  = wr && a == NCH + c;
      wc  = wr && a == 2 * NCH + c;
      it.upd[c] = 1'b0;
      if (clr) begin
        m_latch[c] = m_clrv[c]; it.upd[c] = 1'b1;
      end else if (wd && !m_mode[c]) begin
        m_latch[c] = d[DW-1:0]; it.upd[c] = 1'b1;
      end else if (stb && m_mode[c] && m_pend[c]) begin
        m_latch[c] = m_data[c]; it.upd[c] = 1'b1; m_pend[c] = 1'b0;
      end
      if (wd) begin m_pend[c] = m_mode[c]; m_data[c] = d[DW-1:0]; end
      if (wc) m_clrv[c] = d[DW-1:0];
      it.codes[c*DW +: DW] = m_latch[c];
    end
    if (wr && a == 1) m_mode = d[NCH-1:0];
    if (wr && a == 0) m_gclr = d[1];
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, 0, '0, '0);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (dac_code !== it.codes || latch_upd !== it.upd) begin
        n_bad++;
        $display("FAIL %s: codes %h upd %b, expected codes %h upd %b",
                 it.tag, dac_code, latch_upd, it.codes, it.upd);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_data[c] = '0; m_clrv[c] = '0; m_latch[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle("R10 reset state");

    // clear values
    for (int c = 0; c < NCH; c++) cyc("R1 clrv write", 1, 2*NCH + c, BW'(12'h100 + c), '0);
    idle("R1 clrv no latch effect");

    // immediate mode, boundary codes
    cyc("R2 imm ch0", 1, NCH + 0, 12'hABC, '0);
    cyc("R2 imm ch7 max", 1, NCH + 7, 12'hFFF, '0);
    cyc("R2 imm ch5 zero", 1, NCH + 5, 12'h000, '0);

    // deferred on ch1, ch2
    cyc("R1 mode write", 1, 1, 12'h006, '0);
    cyc("R3 defer ch1", 1, NCH + 1, 12'h111, '0);
    cyc("R3 defer ch2", 1, NCH + 2, 12'h222, '0);
    idle("R3 hold");
    cyc("R4 trigger 0 no load", 1, 0, 12'h000, '0);
    cyc("R4 strobe ch1 ch2", 1, 0, 12'h001, '0);
    cyc("R5 strobe no pending", 1, 0, 12'h001, '0);
    cyc("R3 defer ch2 again", 1, NCH + 2, 12'h333, '0);
    cyc("R5 strobe only ch2", 1, 0, 12'h001, '0);
    cyc("R1 unmapped addr", 1, 31, 12'hFFF, '0);
    cyc("R1 unmapped addr 24", 1, 24, 12'hFFF, '0);
    idle("R1 after unmapped");

    // clear while deferred + pending
    cyc("R3 defer ch1 pend", 1, NCH + 1, 12'h5A5, '0);
    cyc("R6 ext clr ch1 deferred", 0, 0, '0, 8'h02);
    cyc("R6 ext clr ch3 immediate", 0, 0, '0, 8'h08);
    cyc("R7 strobe after clear", 1, 0, 12'h001, '0);

    // clear beats strobe
    cyc("R3 defer ch2 pend", 1, NCH + 2, 12'h7E7, '0);
    cyc("R8 clr beats strobe", 1, 0, 12'h001, 8'h04);
    cyc("R8 pend kept strobe", 1, 0, 12'h001, '0);
    // clear beats immediate write
    cyc("R8 clr beats imm", 1, NCH + 0, 12'h999, 8'h01);
    idle("R8 after clr imm");

    // global clear
    cyc("R6 gclr set", 1, 0, 12'h002, '0);
    cyc("R6 gclr active", 0, 0, '0, '0);
    cyc("R6 gclr release", 1, 0, 12'h000, '0);
    idle("R9 upd drop");

    // all deferred, simultaneous load
    cyc("R1 mode all", 1, 1, 12'h0FF, '0);
    for (int c = 0; c < NCH; c++) cyc("R3 defer all", 1, NCH + c, BW'(12'h800 + 16*c), '0);
    cyc("R4 strobe all", 1, 0, 12'h001, '0);
    cyc("R3 defer ch4", 1, NCH + 4, 12'h444, '0);
    cyc("R1 mode off pend", 1, 1, 12'h000, '0);
    cyc("R5 strobe imm ignored", 1, 0, 12'h001, '0);
    idle("R9 idle");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [NCH-1:0] ex;
      int a;
      ex = ($urandom_range(0, 7) == 0) ? NCH'(1 << $urandom_range(0, NCH-1)) : '0;
      a  = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 1) : $urandom_range(0, 31);
      cyc("R4 random", $urandom_range(0, 3) != 0, a,
          (a == 0) ? BW'($urandom_range(0, 1) | (($urandom_range(0, 9) == 0) ? 2 : 0))
                   : BW'($urandom), ex);
    end
    idle("R9 final");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule